// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block carries short messages between an application processor and an I/O co-processor. A message is a pair made of a 64-bit first word and a 32-bit second word. There are two independent FIFOs. The outbound FIFO, channel 0, always carries traffic from the application processor to the I/O processor. The inbound FIFO, channel 1, always carries traffic the other way. Both processors reach the same register set through one simple 64-bit register bus, which has separate read and write strobes. Each channel has three kinds of register: a control/status register, a pair of send registers and a pair of receive registers.

To send a message, software first writes the first word, which is only staged. It then writes the second word, and that write commits the whole pair to the FIFO in one step. To receive, software reads the first-word register, which returns the head entry and leaves the FIFO as it is. It then reads the second-word register. That read returns the second word and removes the head entry. The same read also reports the FIFO's write pointer, read pointer and occupancy in its upper bits. The full and empty flags of each FIFO also come out as ports, for a separate interrupt block to use.

Top module: `mbox_dual_fifo`

## Requirements
- R1: After reset both FIFOs are empty, and each control register reads 0x0000_0000_0002_0000: the empty flag (bit 17) is set, the full flag (bit 16) is clear, and the error flag (bit 0) is clear.
- R2: Messages leave a channel in the order they were committed, with both words of each pair kept together. A write to send0 alone adds nothing to the FIFO.
- R3: A read of recv0 returns the head entry's 64-bit first word and leaves the FIFO unchanged. If the FIFO is empty, the read returns zero.
- R4: A read of recv1 returns the head entry's second word in bits 31:0 and removes that entry.
- R5: A read of recv1 also returns status fields. They show the state before the pop. Bits 43:40 hold the write pointer and bits 47:44 the read pointer, both taken modulo 16. Bits 51:48 hold the occupancy, saturated at 15. Bits 56:52 hold the occupancy from 0 to 16. Bits 39:32 and 63:57 are zero.
- R6: Control bit 16 is set exactly when the FIFO holds 16 entries. Control bit 17 is set exactly when it holds none.
- R7: A commit while the FIFO is full is dropped, and the contents stay the same. It sets the sticky error flag in control bit 0.
- R8: A read of recv1 while the FIFO is empty returns zero in bits 31:0 and leaves the pointers unchanged. It sets the sticky error flag in control bit 0.
- R9: Writing a control register with bit 0 set clears that channel's error flag. Writing it with bit 0 clear has no effect.
- R10: The two channels are independent. Channel 0 (application to I/O) uses control 0x50, send0 0x60, send1 0x68, recv0 0x70 and recv1 0x78. Channel 1 (I/O to application) uses control 0x80, send0 0x90, send1 0x98, recv0 0xA0 and recv1 0xA8. Reads of any other offset return zero.
- R11: The full and empty output ports of each channel always match bits 16 and 17 of that channel's control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe. A recv1 read pops at the clock edge |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data. Combinational while rd_en_i is high |
| a2i_full_o | output | 1 | Channel 0 FIFO full |
| a2i_empty_o | output | 1 | Channel 0 FIFO empty |
| i2a_full_o | output | 1 | Channel 1 FIFO full |
| i2a_empty_o | output | 1 | Channel 1 FIFO empty |

## Verification
The properties assume that at most one strobe is active in any cycle, so a commit and a pop never happen in the same cycle. The stimulus keeps to this: every access is a single-cycle strobe issued from one bus task. The properties also assume that read data is only meaningful while the read strobe is high. The random phases bias the mix first toward commits and then toward pops. This drives each FIFO through full, overflow, drain and underflow, including a commit into a full FIFO and a pop from an empty one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic [63:0] w0;
    logic [31:0] w1;
  } mbox_msg_t;

  localparam int unsigned FULL_BIT  = 16;
  localparam int unsigned EMPTY_BIT = 17;
  localparam int unsigned ERR_BIT   = 0;

  localparam logic [7:0] OFS_SEND0 = 8'h10;
  localparam logic [7:0] OFS_SEND1 = 8'h18;
  localparam logic [7:0] OFS_RECV0 = 8'h20;
  localparam logic [7:0] OFS_RECV1 = 8'h28;

  function automatic logic [7:0] ctrl_addr(int unsigned ch);
    return (ch == 0) ? 8'h50 : 8'h80;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  mbox_msg_t                msg_i,
  input  logic                     pop_i,
  input  logic                     clr_err_i,
  output mbox_msg_t                head_o,
  output logic                     full_o,
  output logic                     empty_o,
  output logic [$clog2(DEPTH)-1:0] wptr_o,
  output logic [$clog2(DEPTH)-1:0] rptr_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                     err_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  mbox_msg_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= msg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      // set wins over a same-cycle clear
      if ((push_i && full_o) || (pop_i && empty_o)) err_q <= 1'b1;
      else if (clr_err_i)                            err_q <= 1'b0;
    end
  end

  assign head_o  = empty_o ? '0 : mem[rptr_q];
  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = cnt_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CH    = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] rdata_o,
  output logic        full_o,
  output logic        empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [7:0] A_CTRL  = ctrl_addr(CH);
  localparam logic [7:0] A_SEND0 = A_CTRL + OFS_SEND0;
  localparam logic [7:0] A_SEND1 = A_CTRL + OFS_SEND1;
  localparam logic [7:0] A_RECV0 = A_CTRL + OFS_RECV0;
  localparam logic [7:0] A_RECV1 = A_CTRL + OFS_RECV1;

  logic [63:0]      stage_q;
  mbox_msg_t        head, msg_in;
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic             err, push, pop, clr;
  logic [3:0]       icnt_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             stage_q <= '0;
    else if (wr_en_i && addr_i == A_SEND0)   stage_q <= wdata_i;
  end

  assign push   = wr_en_i && (addr_i == A_SEND1);
  assign pop    = rd_en_i && (addr_i == A_RECV1);
  assign clr    = wr_en_i && (addr_i == A_CTRL) && wdata_i[ERR_BIT];
  assign msg_in = '{w0: stage_q, w1: wdata_i[31:0]};

  mbox_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i   (push),
    .msg_i    (msg_in),
    .pop_i    (pop),
    .clr_err_i(clr),
    .head_o   (head),
    .full_o,
    .empty_o,
    .wptr_o   (wptr),
    .rptr_o   (rptr),
    .count_o  (cnt),
    .err_o    (err)
  );

  assign icnt_f = (cnt > CNT_W'(15)) ? 4'hF : 4'(cnt);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_CTRL: begin
          rdata_o[FULL_BIT]  = full_o;
          rdata_o[EMPTY_BIT] = empty_o;
          rdata_o[ERR_BIT]   = err;
        end
        A_RECV0: rdata_o = head.w0;
        A_RECV1: rdata_o = {7'b0, 5'(cnt), icnt_f, 4'(rptr), 4'(wptr), 8'b0, head.w1};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_dual_fifo.sv
module mbox_dual_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] rdata_o,
  output logic        a2i_full_o,
  output logic        a2i_empty_o,
  output logic        i2a_full_o,
  output logic        i2a_empty_o
);
  localparam int unsigned N_CH = 2;

  logic [63:0] ch_rdata [N_CH];
  logic [N_CH-1:0] ch_full, ch_empty;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    mbox_chan #(.DEPTH(DEPTH), .CH(c)) u_chan (
      .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
      .rdata_o(ch_rdata[c]),
      .full_o (ch_full[c]),
      .empty_o(ch_empty[c])
    );
  end

  // channels decode disjoint offsets; non-hit channels drive zero
  assign rdata_o     = ch_rdata[0] | ch_rdata[1];
  assign a2i_full_o  = ch_full[0];
  assign a2i_empty_o = ch_empty[0];
  assign i2a_full_o  = ch_full[1];
  assign i2a_empty_o = ch_empty[1];
endmodule

// File: rtl/mbox_dual_fifo_chk.sv
module mbox_dual_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [7:0]  addr_i,
  input logic [63:0] rdata_o,
  input logic        a2i_full_o,
  input logic        a2i_empty_o,
  input logic        i2a_full_o,
  input logic        i2a_empty_o
);
  // R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a2i_full_o && a2i_empty_o) && !(i2a_full_o && i2a_empty_o));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i == 8'h68 && a2i_full_o) |=> a2i_full_o);

  // R8
  underflow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'hA8 && i2a_empty_o) |-> (rdata_o[31:0] == 32'h0));

  // R8
  underflow_stays_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == 8'h78 && a2i_empty_o) |=> a2i_empty_o);

  // R2
  commit_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i == 8'h98 && i2a_empty_o) |=> !i2a_empty_o);

  // R2
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i == 8'h60) |=> $stable(a2i_empty_o));

  // R11
  ctrl_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'h50) |-> (rdata_o[16] == a2i_full_o && rdata_o[17] == a2i_empty_o));

  // R11
  ctrl_mirror_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'h80) |-> (rdata_o[16] == i2a_full_o && rdata_o[17] == i2a_empty_o));
endmodule

bind mbox_dual_fifo mbox_dual_fifo_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .rdata_o(rdata_o),
  .a2i_full_o(a2i_full_o), .a2i_empty_o(a2i_empty_o),
  .i2a_full_o(i2a_full_o), .i2a_empty_o(i2a_empty_o)
);

// File: tb/mbox_dual_fifo_test.sv
`timescale 1ns/1ps
module mbox_dual_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        a_full, a_empty, b_full, b_empty;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [95:0] mm [2][16];
  int  mwp [2], mrp [2], mcnt [2];
  bit  merr [2];

  always #4 clk = ~clk;

  mbox_dual_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .a2i_full_o(a_full), .a2i_empty_o(a_empty),
    .i2a_full_o(b_full), .i2a_empty_o(b_empty)
  );

  function automatic logic [7:0] base(int d);
    return (d == 0) ? 8'h50 : 8'h80;
  endfunction

  function automatic logic [63:0] exp_ctrl(int d);
    logic [63:0] e = '0;
    e[16] = (mcnt[d] == 16);
    e[17] = (mcnt[d] == 0);
    e[0]  = merr[d];
    return e;
  endfunction

  function automatic logic [63:0] exp_recv1(int d);
    logic [63:0] e = '0;
    e[56:52] = 5'(mcnt[d]);
    e[51:48] = (mcnt[d] > 15) ? 4'hF : 4'(mcnt[d]);
    e[47:44] = 4'(mrp[d]);
    e[43:40] = 4'(mwp[d]);
    e[31:0]  = (mcnt[d] == 0) ? 32'h0 : mm[d][mrp[d]][31:0];
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #2 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic send(int d, logic [63:0] w0, logic [31:0] w1);
    bus_wr(base(d) + 8'h10, w0);
    bus_wr(base(d) + 8'h18, {32'hDEAD_BEEF, w1});
    if (mcnt[d] == 16) merr[d] = 1'b1;
    else begin
      mm[d][mwp[d]] = {w0, w1};
      mwp[d] = (mwp[d] + 1) % 16;
      mcnt[d]++;
    end
  endtask

  task automatic recv(int d);
    logic [63:0] r;
    bus_rd(base(d) + 8'h20, r);
    chk("R3 recv0 head", r, (mcnt[d] == 0) ? 64'h0 : mm[d][mrp[d]][95:32]);
    bus_rd(base(d) + 8'h28, r);
    chk(mcnt[d] == 0 ? "R8 recv1 empty" : "R4 R5 recv1", r, exp_recv1(d));
    if (mcnt[d] == 0) merr[d] = 1'b1;
    else begin
      mrp[d] = (mrp[d] + 1) % 16;
      mcnt[d]--;
    end
  endtask

  task automatic ctrl(int d);
    logic [63:0] r;
    bus_rd(base(d), r);
    chk("R6 R7 control", r, exp_ctrl(d));
    chk("R11 flag ports", (d == 0) ? {62'b0, a_empty, a_full} : {62'b0, b_empty, b_full},
        {62'b0, mcnt[d] == 0, mcnt[d] == 16});
  endtask

  task automatic clr(int d, bit b);
    bus_wr(base(d), {63'b0, b});
    if (b) merr[d] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    int unsigned seed;
    seed = $urandom(32'h1234_5678);
    for (int d = 0; d < 2; d++) begin mwp[d] = 0; mrp[d] = 0; mcnt[d] = 0; merr[d] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h50, r); chk("R1 ctrl a2i", r, 64'h2_0000);
    bus_rd(8'h80, r); chk("R1 ctrl i2a", r, 64'h2_0000);
    // R10 unmapped offset
    bus_rd(8'h58, r); chk("R10 unmapped", r, 64'h0);

    // R2 staging alone does not commit
    bus_wr(8'h60, 64'h1111_2222_3333_4444);
    ctrl(0);
    // R2 R3 R4 R5 ordering and peek
    send(0, 64'hA0A0_0000_0000_0001, 32'h1);
    send(0, 64'hA0A0_0000_0000_0002, 32'h2);
    send(0, 64'hA0A0_0000_0000_0003, 32'h3);
    bus_rd(8'h70, r); chk("R3 peek no pop", r, 64'hA0A0_0000_0000_0001);
    recv(0); recv(0); recv(0); ctrl(0);

    // R6 R7 fill and overflow; R10 other channel untouched
    for (int i = 0; i < 17; i++) send(0, 64'(i) << 8, 32'(i + 100));
    ctrl(0); ctrl(1);
    // R9 clear with bit 0 low: no effect, then clear
    clr(0, 1'b0); ctrl(0);
    clr(0, 1'b1); ctrl(0);
    // R8 drain then underflow
    for (int i = 0; i < 17; i++) recv(0);
    ctrl(0);
    clr(0, 1'b1);
    // R10 reverse channel
    send(1, 64'hBEEF, 32'h55); ctrl(0); recv(1); ctrl(1);

    // random phases: push-heavy then pop-heavy
    for (int ph = 0; ph < 8; ph++) begin
      for (int i = 0; i < 300; i++) begin
        int d = $urandom % 2;
        int k = $urandom % 100;
        int push_pct = (ph % 2 == 0) ? 65 : 25;
        if (k < push_pct) send(d, {$urandom, $urandom}, $urandom);
        else if (k < 90) recv(d);
        else if (k < 96) ctrl(d);
        else clr(d, 1'($urandom));
      end
    end
    ctrl(0); ctrl(1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule